// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt requests from sixteen sources and tells a processor core, through a registered 3-bit level, the most urgent request that is currently allowed through. Every source carries a level (1 to 7, with 0 meaning "off") and a 2-bit priority that ranks it against other sources on the same level. Three of the sources stand for external request pins and sit on fixed levels 1, 4 and 7. The other thirteen are internal sources whose level is set by software.

Software reaches the block through a simple write port. Each source has its own configuration address. Mask and force bits are set or cleared one at a time by writing the source index to a command address, so no read-modify-write is needed. A single global mask holds back every level except 7.

When the core takes an interrupt, it raises an acknowledge with the level it is serving. One cycle later the block returns the vector of the winning source on that level. If nothing on that level qualifies, it returns a fixed spurious vector.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ipl` becomes 0 and `ack_valid` becomes 0. After reset every source is masked, every force bit is clear, every internal level field and every priority field is 0, and the global mask is off. A forced, configured source therefore raises nothing until it is unmasked.
- R2: A write to address n (0 to 15) sets source n's level from `wr_data[2:0]` and its priority from `wr_data[4:3]`. Sources 0, 1 and 2 are external sources with levels fixed at 1, 4 and 7. For these three, the written level bits are ignored and the priority bits are still taken.
- R3: A source whose level field is 0 never qualifies, whether or not it is requesting.
- R4: A write to address 0x10 sets the mask bit of the source whose index is in `wr_data[3:0]`, and a write to address 0x11 clears it. No other mask bit changes. A masked source never qualifies.
- R5: A write to address 0x12 sets the force bit of the source indexed by `wr_data[3:0]`, and a write to address 0x13 clears it. A source with its force bit set counts as requesting whatever the value of its `irq_in` bit. Writes to addresses 0x15 to 0x1F have no effect.
- R6: A write to address 0x14 loads the global mask from `wr_data[0]`. While the global mask is set, sources on levels 1 to 6 do not qualify and level-7 sources still do. Per-source masks apply on every level, including level 7.
- R7: A source qualifies when it is requesting, unmasked, not held back by the global mask, and on a non-zero level. `ipl` shows the highest level among qualifying sources, or 0 if there are none. It is registered, so it reflects the state at the previous clock edge.
- R8: An `ack_req` at a clock edge makes `ack_valid` high for exactly the following cycle. The vector carried with it is 0x40 plus the index of the winner among qualifying sources whose level equals `ack_level`. The winner has the highest priority value, and a tie goes to the lower index. The choice uses the state before any write that lands on the same edge.
- R9: If no qualifying source has level `ack_level` (this includes `ack_level` 0), the acknowledge returns the spurious vector 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request lines, one per source, active high, already synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0-15 source configuration, 0x10-0x14 commands |
| wr_data | input | 5 | Write data |
| ack_req | input | 1 | Core acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| ipl | output | 3 | Highest qualifying level, registered |
| ack_valid | output | 1 | Vector is valid this cycle |
| ack_vector | output | 8 | Vector of the acknowledged source, or the spurious vector |

## Verification
An acknowledge and a register write can land on the same clock edge. In that case the winner must be chosen from the state as it stood before the write. The bench provokes this by acknowledging level 5 in the same cycle as a mask-set command aimed at the current level-5 winner. It expects that source's vector back, and expects the next source in line on a following acknowledge. A behavioural model with plain arrays applies the same rule on every edge: it computes the level and the vector first and applies the write afterwards. The random phase then produces many such collisions against the per-cycle comparison.

// File: rtl/lic_pkg.sv
// Shared constants for the leveled interrupt controller.
// Assumes at least three sources; the first three are the fixed-level external inputs.
package lic_pkg;
    localparam int LVL_W   = 3;
    localparam int PRI_W   = 2;
    localparam int CFG_W   = LVL_W + PRI_W;
    localparam int NUM_EXT = 3;

    // Command offsets above the per-source configuration addresses.
    localparam int MSET_OFS = 0;
    localparam int MCLR_OFS = 1;
    localparam int FSET_OFS = 2;
    localparam int FCLR_OFS = 3;
    localparam int GMSK_OFS = 4;
    localparam int NUM_CMD  = 5;

    // Fixed level of each external source.
    function automatic logic [LVL_W-1:0] ext_level(input int idx);
        case (idx)
            0:       return 3'd1;
            1:       return 3'd4;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/lic_regs.sv
// Software-visible state: per-source level, priority, mask and force bits, plus the global mask.
// Mask and force bits are changed one at a time by index commands. External sources hold fixed levels.
module lic_regs
    import lic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic [NUM_SRC-1:0][PRI_W-1:0] src_pri,
    output logic [NUM_SRC-1:0]            src_mask,
    output logic [NUM_SRC-1:0]            src_frc,
    output logic                          glb_mask
);
    logic             cmd_mset, cmd_mclr, cmd_fset, cmd_fclr, cmd_gmsk;
    logic [IDX_W-1:0] cmd_idx;

    // Decode the command addresses that sit above the configuration block.
    always_comb begin
        cmd_mset = wr_en && (wr_addr == ADDR_W'(NUM_SRC + MSET_OFS));
        cmd_mclr = wr_en && (wr_addr == ADDR_W'(NUM_SRC + MCLR_OFS));
        cmd_fset = wr_en && (wr_addr == ADDR_W'(NUM_SRC + FSET_OFS));
        cmd_fclr = wr_en && (wr_addr == ADDR_W'(NUM_SRC + FCLR_OFS));
        cmd_gmsk = wr_en && (wr_addr == ADDR_W'(NUM_SRC + GMSK_OFS));
        cmd_idx  = wr_data[IDX_W-1:0];
    end

    // Global mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        glb_mask <= 1'b0;
        else if (cmd_gmsk) glb_mask <= wr_data[0];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic             cfg_hit, idx_hit;
        logic [PRI_W-1:0] pri_q;
        logic             mask_q, frc_q;

        assign cfg_hit = wr_en && (wr_addr == ADDR_W'(i));
        assign idx_hit = (cmd_idx == IDX_W'(i));

        // Priority field: taken from every configuration write.
        always_ff @(posedge clk) begin
            if (!rst_n)       pri_q <= '0;
            else if (cfg_hit) pri_q <= wr_data[LVL_W +: PRI_W];
        end

        // Mask bit: set out of reset, changed only by its own index command.
        always_ff @(posedge clk) begin
            if (!rst_n)                   mask_q <= 1'b1;
            else if (cmd_mset && idx_hit) mask_q <= 1'b1;
            else if (cmd_mclr && idx_hit) mask_q <= 1'b0;
        end

        // Force bit: software-asserted request.
        always_ff @(posedge clk) begin
            if (!rst_n)                   frc_q <= 1'b0;
            else if (cmd_fset && idx_hit) frc_q <= 1'b1;
            else if (cmd_fclr && idx_hit) frc_q <= 1'b0;
        end

        assign src_pri[i]  = pri_q;
        assign src_mask[i] = mask_q;
        assign src_frc[i]  = frc_q;

        if (i < NUM_EXT) begin : g_ext
            // External source: level is a wired constant, writes to it are dropped.
            assign src_lvl[i] = ext_level(i);
        end else begin : g_int
            logic [LVL_W-1:0] lvl_q;
            // Internal source: level is programmable.
            always_ff @(posedge clk) begin
                if (!rst_n)       lvl_q <= '0;
                else if (cfg_hit) lvl_q <= wr_data[LVL_W-1:0];
            end
            assign src_lvl[i] = lvl_q;
        end
    end

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mset |=> src_mask[$past(cmd_idx)]);
    assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mclr |=> !src_mask[$past(cmd_idx)]);
    assert_force_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fset |=> src_frc[$past(cmd_idx)]);
endmodule

// File: rtl/lic_select.sv
// Combinational arbitration over the qualifying sources.
// Finds the highest level present, and the winner on one requested level:
// highest priority value wins, and a tie goes to the lower index.
module lic_select
    import lic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]            qual,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    input  logic [NUM_SRC-1:0][PRI_W-1:0] src_pri,
    input  logic [LVL_W-1:0]              match_lvl,
    output logic [LVL_W-1:0]              top_lvl,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx
);
    logic [PRI_W-1:0] best_pri;

    // Ascending scan; a strict compare keeps the lower index on equal priority.
    always_comb begin
        top_lvl  = '0;
        found    = 1'b0;
        win_idx  = '0;
        best_pri = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (src_lvl[i] > top_lvl))
                top_lvl = src_lvl[i];
            if (qual[i] && (src_lvl[i] == match_lvl) && (!found || (src_pri[i] > best_pri))) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                best_pri = src_pri[i];
            end
        end
    end
endmodule

// File: rtl/lic_ack.sv
// Acknowledge response register: captures the winner's vector, or the spurious vector,
// on the edge where the acknowledge is seen. Valid lasts one cycle.
module lic_ack #(
    parameter int               IDX_W    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
    parameter logic [VEC_W-1:0] VEC_SPUR = 8'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             found,
    input  logic [IDX_W-1:0] win_idx,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector
);
    // One-cycle valid pulse that follows each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_valid <= 1'b0;
        else        ack_valid <= ack_req;
    end

    // Vector capture; holds between acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_vector <= '0;
        else if (ack_req) ack_vector <= found ? (VEC_BASE + VEC_W'(win_idx)) : VEC_SPUR;
    end

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);
    assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);
    assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !found) |=> (ack_vector == VEC_SPUR));
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Leveled priority interrupt controller top.
// Qualifies each request against its mask, level and the global mask. It registers the highest
// qualifying level for the core and answers level acknowledges with a vector.
// Assumes irq_in is already synchronous to clk.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int               NUM_SRC  = 16,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
    parameter logic [VEC_W-1:0] VEC_SPUR = 8'h18,
    parameter int               IDX_W    = $clog2(NUM_SRC),
    parameter int               ADDR_W   = $clog2(NUM_SRC + NUM_CMD),
    parameter int               DATA_W   = (IDX_W > CFG_W) ? IDX_W : CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ack_req,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   ipl,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector
);
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic [NUM_SRC-1:0][PRI_W-1:0] src_pri;
    logic [NUM_SRC-1:0]            src_mask, src_frc, qual;
    logic                          glb_mask, found;
    logic [LVL_W-1:0]              top_lvl;
    logic [IDX_W-1:0]              win_idx;

    lic_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_lvl(src_lvl), .src_pri(src_pri), .src_mask(src_mask), .src_frc(src_frc),
        .glb_mask(glb_mask)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
        // Request (pin or force), unmasked, enabled level, and past the global mask unless on level 7.
        assign qual[i] = (irq_in[i] | src_frc[i]) & ~src_mask[i] & (src_lvl[i] != '0)
                       & (~glb_mask | (src_lvl[i] == 3'd7));
    end

    lic_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sel (
        .qual(qual), .src_lvl(src_lvl), .src_pri(src_pri), .match_lvl(ack_level),
        .top_lvl(top_lvl), .found(found), .win_idx(win_idx)
    );

    // Registered level presented to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) ipl <= '0;
        else        ipl <= top_lvl;
    end

    lic_ack #(.IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .found(found), .win_idx(win_idx),
        .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    assert_idle_ipl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |=> (ipl == '0));
    assert_winner_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (qual[win_idx] && (src_lvl[win_idx] == ack_level)));
endmodule

// File: tb/sim_lvl_irq_ctrl.sv
// Bench: behavioural model updated on every edge, compared at every falling edge, plus directed checks.
module sim_lvl_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [4:0]  wr_data = '0;
    logic        ack_req = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [2:0]  ipl;
    logic        ack_valid;
    logic [7:0]  ack_vector;

    int n_cmp = 0, n_bad = 0;
    bit started = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack_req(ack_req), .ack_level(ack_level),
        .ipl(ipl), .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int m_lvl[16], m_pri[16];
    bit m_mask[16], m_frc[16];
    bit m_gm;
    int exp_ipl, exp_vec, best_i, best_p, top, lv;
    bit exp_av;

    function automatic int eff_lvl(int i);
        if (i == 0) return 1;
        if (i == 1) return 4;
        if (i == 2) return 7;
        return m_lvl[i];
    endfunction

    function automatic bit qualifies(int i);
        int l = eff_lvl(i);
        return (irq_in[i] || m_frc[i]) && !m_mask[i] && l != 0 && (!m_gm || l == 7);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_lvl[i] = 0; m_pri[i] = 0; m_mask[i] = 1; m_frc[i] = 0;
            end
            m_gm = 0; exp_ipl = 0; exp_av = 0;
        end else begin
            // Decide level and vector from pre-edge state first.
            top = 0; best_i = -1; best_p = -1;
            for (int i = 0; i < 16; i++) begin
                if (qualifies(i)) begin
                    lv = eff_lvl(i);
                    if (lv > top) top = lv;
                    if (lv == int'(ack_level) && m_pri[i] > best_p) begin
                        best_p = m_pri[i]; best_i = i;
                    end
                end
            end
            exp_ipl = top;
            exp_av  = ack_req;
            if (ack_req) exp_vec = (best_i < 0) ? 'h18 : ('h40 + best_i);
            // Then apply the write.
            if (wr_en) begin
                if (wr_addr < 16) begin
                    m_lvl[wr_addr] = wr_data[2:0];
                    m_pri[wr_addr] = wr_data[4:3];
                end else if (wr_addr == 5'h10) m_mask[wr_data[3:0]] = 1;
                else if (wr_addr == 5'h11) m_mask[wr_data[3:0]] = 0;
                else if (wr_addr == 5'h12) m_frc[wr_data[3:0]] = 1;
                else if (wr_addr == 5'h13) m_frc[wr_data[3:0]] = 0;
                else if (wr_addr == 5'h14) m_gm = wr_data[0];
            end
        end
        started = 1;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R7 ipl vs model", ipl, exp_ipl);
            chk("R8 ack_valid vs model", ack_valid, exp_av);
            if (exp_av) chk((exp_vec == 'h18) ? "R9 vector vs model" : "R8 vector vs model",
                            ack_vector, exp_vec);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = 5'(a); wr_data = 5'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_irq(input int i, input bit v);
        @(negedge clk); irq_in[i] = v;
        @(negedge clk);
    endtask

    task automatic ack(input int l, input string tag, input int exp);
        @(negedge clk); ack_req = 1'b1; ack_level = 3'(l);
        @(negedge clk); ack_req = 1'b0;
        chk(tag, ack_vector, exp);
        chk(tag, ack_valid, 1);
    endtask

    task automatic summary;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 ipl after reset", ipl, 0);
        chk("R1 ack_valid after reset", ack_valid, 0);
        // Source 5 on level 3, forced: still masked from reset.
        wr(5, 3);
        wr('h12, 5);
        idle(1);
        chk("R1 masked out of reset", ipl, 0);
        wr('h11, 5);
        idle(1);
        chk("R4 unmask raises level", ipl, 3);
        ack(3, "R5 forced source vector", 'h45);
        wr('h13, 5);
        idle(1);
        chk("R5 force cleared", ipl, 0);
        ack(3, "R9 empty level spurious", 'h18);
        // External source 0: written level ignored.
        wr(0, (2 << 3) | 6);
        wr('h11, 0);
        set_irq(0, 1);
        chk("R2 external fixed level 1", ipl, 1);
        ack(1, "R2 external vector", 'h40);
        ack(6, "R2 written level ignored", 'h18);
        wr('h11, 2);
        set_irq(2, 1);
        chk("R2 external level 7", ipl, 7);
        set_irq(2, 0);
        chk("R2 level 7 dropped", ipl, 1);
        // Level 0 disables.
        wr(6, 3 << 3);
        wr('h11, 6);
        set_irq(6, 1);
        chk("R3 level zero ignored", ipl, 1);
        ack(0, "R3 level zero spurious", 'h18);
        // Priority and tie.
        wr(8, (1 << 3) | 5);
        wr(9, (3 << 3) | 5);
        wr(10, (3 << 3) | 5);
        wr('h11, 8); wr('h11, 9); wr('h11, 10);
        @(negedge clk); irq_in[10:8] = 3'b111;
        idle(1);
        chk("R7 highest level", ipl, 5);
        ack(5, "R8 priority then lower index", 'h49);
        // Global mask.
        wr('h14, 1);
        idle(1);
        chk("R6 global mask blocks 1-6", ipl, 0);
        set_irq(2, 1);
        chk("R6 level 7 passes global mask", ipl, 7);
        set_irq(2, 0);
        wr('h14, 0);
        idle(1);
        chk("R6 global mask released", ipl, 5);
        wr('h10, 9);
        ack(5, "R6 per-source mask", 'h4a);
        // Acknowledge and mask write on the same edge.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'h10; wr_data = 5'd10;
        ack_req = 1'b1; ack_level = 3'd5;
        @(negedge clk);
        wr_en = 1'b0; ack_req = 1'b0;
        chk("R8 ack uses pre-write state", ack_vector, 'h4a);
        ack(5, "R8 next in line after mask", 'h48);
        // Random traffic checked against the model every cycle.
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            irq_in    = 16'($urandom);
            wr_en     = ($urandom % 3) == 0;
            wr_addr   = 5'($urandom % 24);
            wr_data   = 5'($urandom);
            ack_req   = ($urandom % 3) == 0;
            ack_level = 3'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; ack_req = 1'b0;
        idle(2);
        summary();
    end
endmodule